// File: doc/BRIEF.md
# Flash Controller Interrupt and Status Unit

This unit sits beside a flash controller datapath and gathers its event signals: device ready, controller ready, ECC ready, decode error with a corrected-symbol count, decode failure and write-protect fault. From these it builds two status views. The raw view shows the ready signals live and keeps the outcome of the latest decode (error seen, count, failure) until the next decode starts. The latched view records the rising edge of every event in a sticky flag.

Software reads both views over a small synchronous register port. A read of the latched view returns the flags and clears them. A mask register picks which latched flags drive a single active-high, level-sensitive interrupt line. A separate output is high only when the device and the controller are both ready.

Top module: `flash_irq_status_unit`

## Requirements
- R1: Latched flag positions (address 1) are bit 5 device ready, bit 4 controller ready, bit 3 decode failure, bit 2 decode error, bit 1 ECC ready and bit 0 write-protect fault. A flag is set on the clock edge at which its input is first seen high after being low.
- R2: An input that stays high does not set its latched flag again after a read has cleared it.
- R3: A read strobe at address 1 returns the latched flags in bits 5:0 of the read data, with bits 7:6 zero, one cycle after the strobe, and clears the flags it returned.
- R4: An event rising edge in the same cycle as a clearing read is kept latched and appears in the next read.
- R5: The interrupt output is high exactly when some latched flag and its mask bit are both 1. It stays high until a clearing read.
- R6: The mask register at address 2 is written with bits 5:0 of the write data, uses the latched bit order of R1, reads back in bits 5:0, and resets to zero.
- R7: Raw status (address 0) bit 0 device ready, bit 1 controller ready and bit 2 ECC ready show their inputs at the clock edge of the read strobe.
- R8: Raw bit 3 (errors detected) and bits 5:4 (corrected count minus one, as given with the decode-error pulse) are captured on a decode-error pulse. Raw bit 6 (decode failure) is set by a decode-failure pulse. These bits hold until a decode-start pulse clears them.
- R9: The transfer-ready output is high only when the device-ready and controller-ready inputs are both high.
- R10: After reset the latched flags, the mask, the raw sticky fields, the read data and the interrupt are all zero. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_rdy_i | input | 1 | Flash device ready level |
| ctl_rdy_i | input | 1 | Controller ready level |
| ecc_rdy_i | input | 1 | ECC engine ready |
| dec_start_i | input | 1 | Pulse: a new decode begins |
| dec_err_i | input | 1 | Pulse: decode corrected errors |
| dec_cnt_i | input | 2 | Corrected symbols minus one, valid with dec_err_i |
| dec_fail_i | input | 1 | Pulse: decode could not correct |
| wp_fault_i | input | 1 | Write-protect fault |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register address (0 raw, 1 latched, 2 mask) |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt, active high, level |
| xfer_ready_o | output | 1 | Device and controller both ready |

## Verification
The hardest case to reach from the ports is an event edge that lands in the same cycle as a clearing read. The bench drives the read strobe and the event input on the same falling edge. It then checks that the returned data lacks the new flag and that a second read shows it. A second hard case is a level that stays high across a clear. The bench holds device ready high over several reads and expects the flag to stay clear. The main sweep walks every event through all 64 mask values and computes the expected interrupt and read data from the bit order.

// File: rtl/fisu_pkg.sv
package fisu_pkg;
   localparam int NUM_EVT = 6;
   // latched / mask bit positions
   localparam int LB_WP    = 0;
   localparam int LB_ECC   = 1;
   localparam int LB_DERR  = 2;
   localparam int LB_DFAIL = 3;
   localparam int LB_CTL   = 4;
   localparam int LB_DEV   = 5;
   typedef enum logic [1:0] {
      ADR_RAW  = 2'd0,
      ADR_LAT  = 2'd1,
      ADR_MASK = 2'd2,
      ADR_NONE = 2'd3
   } reg_addr_t;
endpackage

// File: rtl/fisu_edge_latch.sv
module fisu_edge_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic ev_i,
   input  logic clr_i,
   output logic lat_o
);
   logic prev_q;
   logic rise;

   assign rise = ev_i & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         lat_o  <= 1'b0;
      end else begin
         prev_q <= ev_i;
         lat_o  <= rise | (lat_o & ~clr_i);
      end
   end

   AST_EDGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i && !prev_q) |=> lat_o); // R4
endmodule

// File: rtl/fisu_raw_status.sv
module fisu_raw_status #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dev_rdy_i,
   input  logic              ctl_rdy_i,
   input  logic              ecc_rdy_i,
   input  logic              dec_start_i,
   input  logic              dec_err_i,
   input  logic [CNT_W-1:0]  dec_cnt_i,
   input  logic              dec_fail_i,
   output logic [DATA_W-1:0] raw_o
);
   localparam int CNT_LSB  = 4;
   localparam int FAIL_BIT = CNT_LSB + CNT_W;

   if (DATA_W < FAIL_BIT + 1) begin : g_bad_width
      $error("fisu_raw_status: DATA_W too small for raw layout");
   end

   logic             err_q;
   logic             fail_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q  <= 1'b0;
         fail_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         if (dec_err_i) begin
            err_q <= 1'b1;
            cnt_q <= dec_cnt_i;
         end else if (dec_start_i) begin
            err_q <= 1'b0;
            cnt_q <= '0;
         end
         if (dec_fail_i)       fail_q <= 1'b1;
         else if (dec_start_i) fail_q <= 1'b0;
      end
   end

   always_comb begin
      raw_o                           = '0;
      raw_o[0]                        = dev_rdy_i;
      raw_o[1]                        = ctl_rdy_i;
      raw_o[2]                        = ecc_rdy_i;
      raw_o[3]                        = err_q;
      raw_o[CNT_LSB +: CNT_W]         = cnt_q;
      raw_o[FAIL_BIT]                 = fail_q;
   end

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec_start_i && !dec_err_i && !dec_fail_i) |=>
      $stable(raw_o[FAIL_BIT:3])); // R8
endmodule

// File: rtl/fisu_irq_out.sv
module fisu_irq_out #(
   parameter int N       = 6,
   parameter bit REG_OUT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lat_i,
   input  logic [N-1:0] mask_i,
   output logic         irq_o
);
   logic hit;
   assign hit = |(lat_i & mask_i);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= hit;
      end
   end else begin : g_comb
      assign irq_o = hit;
   end
endmodule

// File: rtl/flash_irq_status_unit.sv
module flash_irq_status_unit #(
   parameter int DATA_W  = 8,
   parameter int CNT_W   = 2,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dev_rdy_i,
   input  logic              ctl_rdy_i,
   input  logic              ecc_rdy_i,
   input  logic              dec_start_i,
   input  logic              dec_err_i,
   input  logic [CNT_W-1:0]  dec_cnt_i,
   input  logic              dec_fail_i,
   input  logic              wp_fault_i,
   input  logic              rd_en_i,
   input  logic              wr_en_i,
   input  logic [1:0]        addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              irq_o,
   output logic              xfer_ready_o
);
   import fisu_pkg::*;
   localparam int N = NUM_EVT;

   if (DATA_W < N) begin : g_bad_data_w
      $error("flash_irq_status_unit: DATA_W narrower than event count");
   end
   if (CNT_W < 1) begin : g_bad_cnt_w
      $error("flash_irq_status_unit: CNT_W must be at least 1");
   end

   logic [N-1:0]      evt;
   logic [N-1:0]      lat;
   logic [N-1:0]      mask_q;
   logic [DATA_W-1:0] raw;
   logic              clr;

   always_comb begin
      evt           = '0;
      evt[LB_WP]    = wp_fault_i;
      evt[LB_ECC]   = ecc_rdy_i;
      evt[LB_DERR]  = dec_err_i;
      evt[LB_DFAIL] = dec_fail_i;
      evt[LB_CTL]   = ctl_rdy_i;
      evt[LB_DEV]   = dev_rdy_i;
   end

   assign clr = rd_en_i && (addr_i == ADR_LAT);

   for (genvar i = 0; i < N; i++) begin : g_evt
      fisu_edge_latch u_lat (
         .clk   (clk),
         .rst_n (rst_n),
         .ev_i  (evt[i]),
         .clr_i (clr),
         .lat_o (lat[i])
      );
   end

   fisu_raw_status #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_raw (
      .clk         (clk),
      .rst_n       (rst_n),
      .dev_rdy_i   (dev_rdy_i),
      .ctl_rdy_i   (ctl_rdy_i),
      .ecc_rdy_i   (ecc_rdy_i),
      .dec_start_i (dec_start_i),
      .dec_err_i   (dec_err_i),
      .dec_cnt_i   (dec_cnt_i),
      .dec_fail_i  (dec_fail_i),
      .raw_o       (raw)
   );

   fisu_irq_out #(.N(N), .REG_OUT(IRQ_REG)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .lat_i  (lat),
      .mask_i (mask_q),
      .irq_o  (irq_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q    <= '0;
         rd_data_o <= '0;
      end else begin
         if (wr_en_i && addr_i == ADR_MASK) mask_q <= wr_data_i[N-1:0];
         if (rd_en_i) begin
            unique case (addr_i)
               ADR_RAW:  rd_data_o <= raw;
               ADR_LAT:  rd_data_o <= DATA_W'(lat);
               ADR_MASK: rd_data_o <= DATA_W'(mask_q);
               default:  rd_data_o <= '0;
            endcase
         end
      end
   end

   assign xfer_ready_o = raw[0] & raw[1];

   AST_RD_RETURNS_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && addr_i == ADR_LAT) |=> rd_data_o == DATA_W'($past(lat))); // R3
   AST_READY_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ready_o |-> (dev_rdy_i && ctl_rdy_i)); // R9

   if (!IRQ_REG) begin : g_irq_chk
      AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_o && !clr) |=> irq_o); // R5
   end
endmodule

// File: tb/tb_flash_irq_status_unit.sv
module tb_flash_irq_status_unit;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       dev_rdy, ctl_rdy, ecc_rdy, dec_start, dec_err, dec_fail, wp_fault;
   logic [1:0] dec_cnt;
   logic       rd_en, wr_en;
   logic [1:0] addr;
   logic [7:0] wr_data;
   logic [7:0] rd_data;
   logic       irq, xfer_ready;
   int         n_run = 0;
   int         n_fail = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   flash_irq_status_unit dut (
      .clk(clk), .rst_n(rst_n),
      .dev_rdy_i(dev_rdy), .ctl_rdy_i(ctl_rdy), .ecc_rdy_i(ecc_rdy),
      .dec_start_i(dec_start), .dec_err_i(dec_err), .dec_cnt_i(dec_cnt),
      .dec_fail_i(dec_fail), .wp_fault_i(wp_fault),
      .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wr_data),
      .rd_data_o(rd_data), .irq_o(irq), .xfer_ready_o(xfer_ready)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // drive event by latched bit position (R1 order)
   task automatic set_ev(input int idx, input logic v);
      case (idx)
         5: dev_rdy  = v;
         4: ctl_rdy  = v;
         3: dec_fail = v;
         2: dec_err  = v;
         1: ecc_rdy  = v;
         default: wp_fault = v;
      endcase
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic rd(input logic [1:0] a);
      rd_en = 1'b1; addr = a;
      step();
      rd_en = 1'b0;
   endtask

   task automatic wr_mask(input logic [7:0] d);
      wr_en = 1'b1; addr = 2'd2; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hang expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      {dev_rdy, ctl_rdy, ecc_rdy, dec_start, dec_err, dec_fail, wp_fault} = '0;
      dec_cnt = 2'd0; rd_en = 1'b0; wr_en = 1'b0; addr = 2'd0; wr_data = 8'd0;
      repeat (3) step();
      // R10 reset state
      chk("R10 irq", {7'd0, irq}, 8'h00);
      chk("R10 rd_data", rd_data, 8'h00);
      rst_n = 1'b1;
      step();
      rd(2'd0); chk("R10 raw", rd_data, 8'h00);
      rd(2'd1); chk("R10 latched", rd_data, 8'h00);
      rd(2'd2); chk("R10 mask", rd_data, 8'h00);
      rd(2'd3); chk("R10 addr3", rd_data, 8'h00);

      // R6 mask write / read back
      wr_mask(8'hFF); rd(2'd2); chk("R6 mask readback", rd_data, 8'h3F);
      wr_mask(8'h15); rd(2'd2); chk("R6 mask readback", rd_data, 8'h15);

      // R1 / R3 / R5 sweep: every event against every mask
      for (int e = 0; e < 6; e++) begin
         for (int m = 0; m < 64; m++) begin
            wr_mask(8'(m));
            set_ev(e, 1'b1); step(); set_ev(e, 1'b0);
            chk("R5 irq after event", {7'd0, irq}, {7'd0, m[e]});
            step();
            chk("R5 irq holds", {7'd0, irq}, {7'd0, m[e]});
            rd(2'd1);
            chk("R1 R3 latched bit", rd_data, 8'(1 << e));
            chk("R3 irq after clear", {7'd0, irq}, 8'h00);
            rd(2'd1);
            chk("R3 cleared", rd_data, 8'h00);
         end
      end
      dec_start = 1'b1; step(); dec_start = 1'b0;

      // R2 held level does not re-set
      wr_mask(8'h3F);
      dev_rdy = 1'b1; step();
      rd(2'd1); chk("R2 first edge", rd_data, 8'h20);
      repeat (3) step();
      chk("R2 irq stays low", {7'd0, irq}, 8'h00);
      rd(2'd1); chk("R2 no re-set", rd_data, 8'h00);
      dev_rdy = 1'b0; step();

      // R4 event during clearing read
      rd_en = 1'b1; addr = 2'd1; wp_fault = 1'b1;
      step();
      rd_en = 1'b0; wp_fault = 1'b0;
      chk("R4 read lacks new flag", rd_data, 8'h00);
      chk("R4 irq from kept flag", {7'd0, irq}, 8'h01);
      rd(2'd1); chk("R4 flag kept", rd_data, 8'h01);

      // R7 live raw ready bits
      dev_rdy = 1'b1; ctl_rdy = 1'b0; ecc_rdy = 1'b1;
      rd(2'd0); chk("R7 raw live", rd_data, 8'h05);
      dev_rdy = 1'b0; ctl_rdy = 1'b1; ecc_rdy = 1'b0;
      rd(2'd0); chk("R7 raw live", rd_data, 8'h02);

      // R9 transfer ready
      for (int k = 0; k < 4; k++) begin
         dev_rdy = k[0]; ctl_rdy = k[1];
         #1;
         chk("R9 xfer_ready", {7'd0, xfer_ready}, {7'd0, (k == 3)});
      end
      dev_rdy = 1'b0; ctl_rdy = 1'b0;
      step();

      // R8 sticky decode result with each count value
      for (int c = 0; c < 4; c++) begin
         dec_start = 1'b1; step(); dec_start = 1'b0;
         rd(2'd0); chk("R8 cleared by start", rd_data, 8'h00);
         dec_err = 1'b1; dec_cnt = 2'(c); step(); dec_err = 1'b0; dec_cnt = 2'd0;
         repeat (2) step();
         rd(2'd0); chk("R8 err and count held", rd_data, 8'(8 | (c << 4)));
      end
      dec_fail = 1'b1; step(); dec_fail = 1'b0;
      rd(2'd0); chk("R8 fail held", rd_data, 8'h78);
      dec_start = 1'b1; step(); dec_start = 1'b0;
      rd(2'd0); chk("R8 fail cleared", rd_data, 8'h00);
      rd(2'd1); // drain latched flags

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule